// File: doc/BRIEF.md
# Per-Pin GPIO Configuration Bank

This block holds the configuration and data registers for a bank of general-purpose pins, reached through a small memory-mapped read/write bus. Every pin owns two 32-bit words. The control word picks the alternate function that drives the pad, the drive-strength code, the bias mode and the output enable. The I/O word returns the synchronized pad level and holds the value the pin drives when it is a plain GPIO. The bank drives per-pin output, output-enable, drive-code and bias-code signals straight to the pad cells.

A single power-hold register sits apart from the pin words. Its bit 0 drives the power-keep output, so software can drop the supply latch by writing zero.

Bus accesses run through a three-state sequencer. `ST_IDLE` accepts a request when `bus_valid` is high and moves to `ST_WRITE` or `ST_READ`, depending on `bus_write`. `ST_WRITE` commits the captured write and `ST_READ` presents the read data with `bus_rvalid`. Both states then return to `ST_IDLE`. Pin `p` has its control word at byte address `16*p` and its I/O word at `16*p + 4`. The power-hold register is at `0x820`.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset:
  - every control word reads 0, which means function 0, input direction, drive code 0 and no bias;
  - every output bit is 0 and every pad output is 0;
  - `power_keep` is 1.
- R2: A request is accepted on a rising edge where `bus_ready` and `bus_valid` are both high. `bus_ready` is low in the next cycle.
  - For a read, `bus_rvalid` is high with the data in that next cycle.
  - For a write, the register takes its new value at the end of that next cycle.
- R3: Control word layout:
  - bits 1:0: bias
  - bits 4:2: function select
  - bits 8:6: drive code
  - bit 9: output enable

  All other bits read as 0. Writing 0xFFFFFFFF reads back 0x3DF.
- R4: `pad_drive` of a pin equals control bits 8:6, where code c means (c+1)*2 mA. `pad_bias` equals bits 1:0, coded 0 none, 1 pull-down, 2 keeper, 3 pull-up.
- R5: With function 0, `pad_oe` of the pin equals control bit 9.
- R6: I/O word layout:
  - bit 1 is the read/write output value, driven on `pad_out` with function 0;
  - bit 0 is read-only and shows the input level; writes to it have no effect.
- R7: `pin_in` passes through two flops before it reaches I/O bit 0. A read accepted on the first edge after the pin changes still returns the old level.
- R8: A nonzero function f routes `alt_out[p*7 + f-1]` and `alt_oe[p*7 + f-1]` to `pad_out` and `pad_oe` of pin p. The I/O output bit and control bit 9 are then ignored.
- R9: The power-hold register at 0x820 stores `bus_wdata[0]` and reads it back in bit 0. `power_keep` follows it, so writing 0 deasserts `power_keep`.
- R10: A read of an unmapped address returns 0, and a write to one changes no register. Unmapped addresses are:
  - pins at or above the pin count;
  - word offsets 8 and 12 within a pin;
  - unaligned addresses;
  - any address other than 0x820 outside the pin area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Sequencer idle, request can be accepted |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| pin_in | input | NPINS | Pad input levels (asynchronous) |
| alt_out | input | NPINS*7 | Alternate-function output values, 7 per pin |
| alt_oe | input | NPINS*7 | Alternate-function output enables, 7 per pin |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| pad_drive | output | NPINS*3 | Drive-strength code per pin |
| pad_bias | output | NPINS*2 | Bias code per pin |
| power_keep | output | 1 | Power-hold output |

## Verification
The hardest situation to reach is the cycle in which the synchronizer still holds the old pad level while the pin has already changed. Observing it needs a read that is accepted on the very first edge after the change. The bench changes `pin_in` on the same falling edge on which it raises `bus_valid` with the sequencer idle. The read is then accepted on the next rising edge, and the scoreboard expects the old level. A second read expects the new one. The alternate-function path is checked by flipping `alt_out` while the control word stays fixed, with the output bit and output enable set to disagree with the routed values.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

    localparam int DATA_W     = 32;
    localparam int BIAS_LSB   = 0;
    localparam int BIAS_W     = 2;
    localparam int FUNC_LSB   = 2;
    localparam int FUNC_W     = 3;
    localparam int DRV_LSB    = 6;
    localparam int DRV_W      = 3;
    localparam int OE_BIT     = 9;
    localparam int IO_IN_BIT  = 0;
    localparam int IO_OUT_BIT = 1;
    localparam int NALT       = (1 << FUNC_W) - 1;
    localparam int WORD_CTL   = 0;
    localparam int WORD_IO    = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } bus_state_e;

    typedef enum logic [BIAS_W-1:0] {
        BIAS_NONE = 2'd0,
        BIAS_DOWN = 2'd1,
        BIAS_KEEP = 2'd2,
        BIAS_UP   = 2'd3
    } bias_e;

    typedef struct packed {
        logic              oe;
        logic [DRV_W-1:0]  drive;
        logic [FUNC_W-1:0] func;
        bias_e             bias;
    } ctl_t;

    function automatic ctl_t ctl_unpack(input logic [DATA_W-1:0] w);
        ctl_t c;
        c.oe    = w[OE_BIT];
        c.drive = w[DRV_LSB +: DRV_W];
        c.func  = w[FUNC_LSB +: FUNC_W];
        c.bias  = bias_e'(w[BIAS_LSB +: BIAS_W]);
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_pack(input ctl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[OE_BIT]              = c.oe;
        w[DRV_LSB +: DRV_W]    = c.drive;
        w[FUNC_LSB +: FUNC_W]  = c.func;
        w[BIAS_LSB +: BIAS_W]  = c.bias;
        return w;
    endfunction

endpackage

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_cfg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic              cmd_wr,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata
);

    bus_state_e state_q, state_d;
    logic       accept;

    assign accept = bus_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (bus_valid) state_d = bus_write ? ST_WRITE : ST_READ;
            ST_WRITE: state_d = ST_IDLE;
            ST_READ:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cmd_addr  <= '0;
            cmd_wdata <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cmd_addr  <= bus_addr;
                cmd_wdata <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_ready  = 1'b0;
        bus_rvalid = 1'b0;
        cmd_wr     = 1'b0;
        unique case (state_q)
            ST_IDLE:  bus_ready  = 1'b1;
            ST_WRITE: cmd_wr     = 1'b1;
            ST_READ:  bus_rvalid = 1'b1;
            default:  bus_ready  = 1'b0;
        endcase
    end

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !bus_ready);

    // R2
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !bus_write) |=> bus_rvalid);

    // R2
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rvalid, cmd_wr}));

endmodule

// File: rtl/gpio_addr_map.sv
module gpio_addr_map
    import gpio_cfg_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter int              NPINS     = 8,
    parameter logic [ADDR_W-1:0] HOLD_ADDR = 12'h820
) (
    input  logic [ADDR_W-1:0]                        addr,
    output logic [(NPINS > 1 ? $clog2(NPINS) : 1)-1:0] pin_sel,
    output logic                                     hit_ctl,
    output logic                                     hit_io,
    output logic                                     hit_hold
);

    localparam int                PIN_W     = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam int                FIELD_W   = ADDR_W - 4;
    localparam logic [FIELD_W-1:0] PIN_LIMIT = FIELD_W'(NPINS);

    logic [FIELD_W-1:0] pin_field;
    logic [1:0]         word_sel;
    logic               aligned;
    logic               in_pins;

    assign pin_field = addr[ADDR_W-1:4];
    assign word_sel  = addr[3:2];
    assign aligned   = (addr[1:0] == 2'b00);
    assign in_pins   = aligned && (pin_field < PIN_LIMIT);
    assign pin_sel   = pin_field[PIN_W-1:0];
    assign hit_ctl   = in_pins && (word_sel == 2'(WORD_CTL));
    assign hit_io    = in_pins && (word_sel == 2'(WORD_IO));
    assign hit_hold  = (addr == HOLD_ADDR);

    // R10
    single_target_chk: assert final ($onehot0({hit_ctl, hit_io, hit_hold}));

endmodule

// File: rtl/gpio_pin_slot.sv
module gpio_pin_slot
    import gpio_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_io,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pin_in,
    input  logic [NALT-1:0]   alt_out,
    input  logic [NALT-1:0]   alt_oe,
    output logic [DATA_W-1:0] ctl_word,
    output logic [DATA_W-1:0] io_word,
    output logic              pad_out,
    output logic              pad_oe,
    output logic [DRV_W-1:0]  pad_drive,
    output logic [BIAS_W-1:0] pad_bias
);

    ctl_t              ctl_q;
    logic              out_q;
    logic [1:0]        sync_q;
    logic [FUNC_W-1:0] alt_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            out_q  <= 1'b0;
            sync_q <= '0;
        end else begin
            if (wr_ctl) ctl_q <= ctl_unpack(wdata);
            if (wr_io)  out_q <= wdata[IO_OUT_BIT];
            sync_q <= {sync_q[0], pin_in};
        end
    end

    assign alt_idx = ctl_q.func - FUNC_W'(1);

    always_comb begin
        if (ctl_q.func == '0) begin
            pad_out = out_q;
            pad_oe  = ctl_q.oe;
        end else begin
            pad_out = alt_out[alt_idx];
            pad_oe  = alt_oe[alt_idx];
        end
    end

    assign pad_drive = ctl_q.drive;
    assign pad_bias  = ctl_q.bias;
    assign ctl_word  = ctl_pack(ctl_q);

    always_comb begin
        io_word             = '0;
        io_word[IO_IN_BIT]  = sync_q[1];
        io_word[IO_OUT_BIT] = out_q;
    end

    logic [1:0] sync_age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              sync_age <= '0;
        else if (sync_age != 2'd2) sync_age <= sync_age + 2'd1;
    end

    // R7
    two_flop_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_age == 2'd2) |-> (io_word[IO_IN_BIT] == $past(pin_in, 2)));

    // R10
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctl |=> $stable(ctl_word));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_io |=> $stable(io_word[IO_OUT_BIT]));

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
    import gpio_cfg_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                NPINS     = 8,
    parameter logic [ADDR_W-1:0] HOLD_ADDR = 12'h820
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic                    bus_ready,
    output logic                    bus_rvalid,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [NPINS-1:0]        pin_in,
    input  logic [NPINS*NALT-1:0]   alt_out,
    input  logic [NPINS*NALT-1:0]   alt_oe,
    output logic [NPINS-1:0]        pad_out,
    output logic [NPINS-1:0]        pad_oe,
    output logic [NPINS*DRV_W-1:0]  pad_drive,
    output logic [NPINS*BIAS_W-1:0] pad_bias,
    output logic                    power_keep
);

    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1;

    logic              cmd_wr;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata;
    logic [PIN_W-1:0]  pin_sel;
    logic              hit_ctl, hit_io, hit_hold;
    logic              hold_q;
    logic [DATA_W-1:0] ctl_words [NPINS];
    logic [DATA_W-1:0] io_words  [NPINS];

    gpio_bus_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_ready  (bus_ready),
        .bus_rvalid (bus_rvalid),
        .cmd_wr     (cmd_wr),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata)
    );

    gpio_addr_map #(.ADDR_W(ADDR_W), .NPINS(NPINS), .HOLD_ADDR(HOLD_ADDR)) u_map (
        .addr     (cmd_addr),
        .pin_sel  (pin_sel),
        .hit_ctl  (hit_ctl),
        .hit_io   (hit_io),
        .hit_hold (hit_hold)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic sel_me;
        assign sel_me = (pin_sel == PIN_W'(p));

        gpio_pin_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctl    (cmd_wr && hit_ctl && sel_me),
            .wr_io     (cmd_wr && hit_io && sel_me),
            .wdata     (cmd_wdata),
            .pin_in    (pin_in[p]),
            .alt_out   (alt_out[p*NALT +: NALT]),
            .alt_oe    (alt_oe[p*NALT +: NALT]),
            .ctl_word  (ctl_words[p]),
            .io_word   (io_words[p]),
            .pad_out   (pad_out[p]),
            .pad_oe    (pad_oe[p]),
            .pad_drive (pad_drive[p*DRV_W +: DRV_W]),
            .pad_bias  (pad_bias[p*BIAS_W +: BIAS_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    hold_q <= 1'b1;
        else if (cmd_wr && hit_hold)   hold_q <= cmd_wdata[0];
    end

    assign power_keep = hold_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_rvalid) begin
            if (hit_ctl)       bus_rdata = ctl_words[pin_sel];
            else if (hit_io)   bus_rdata = io_words[pin_sel];
            else if (hit_hold) bus_rdata = {{(DATA_W-1){1'b0}}, hold_q};
        end
    end

    // R9
    keep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(power_keep) |-> $past(cmd_wr && hit_hold));

    // R10
    quiet_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> (bus_rdata == '0));

endmodule

// File: tb/tb_gpio_pin_bank.sv
`timescale 1ns/1ps
module tb_gpio_pin_bank;

    localparam int NP   = 8;
    localparam int NA   = 7;
    localparam int AW   = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic            bus_ready, bus_rvalid;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pin_in = '0;
    logic [NP*NA-1:0] alt_out = '0;
    logic [NP*NA-1:0] alt_oe = '0;
    logic [NP-1:0]   pad_out, pad_oe;
    logic [NP*3-1:0] pad_drive;
    logic [NP*2-1:0] pad_bias;
    logic            power_keep;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    gpio_pin_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_drive(pad_drive), .pad_bias(pad_bias), .power_keep(power_keep)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data when the design presents it
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2 actual=unexpected rvalid expected=no read pending");
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        while (!bus_ready) @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        check("R2 busy after write accept", {31'b0, bus_ready}, 32'd0);
        bus_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        while (!bus_ready) @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        check("R2 rvalid after read accept", {31'b0, bus_rvalid}, 32'd1);
        bus_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NP-1:0]   s_out, s_oe;
        logic [NP*3-1:0] s_drv;
        logic [NP*2-1:0] s_bias;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", 32'(pad_oe), 32'd0);
        check("R1 pad_out", 32'(pad_out), 32'd0);
        check("R1 pad_drive", 32'(pad_drive), 32'd0);
        check("R1 pad_bias", 32'(pad_bias), 32'd0);
        check("R1 power_keep", {31'b0, power_keep}, 32'd1);
        bus_rd(12'h000, 32'h0, "R1 ctl pin0");
        bus_rd(12'h074, 32'h0, "R1 io pin7");

        // R3 R4 R5: pin3 oe=1 drive=5 bias=keeper -> 0x342
        bus_wr(12'h030, 32'h0000_0342);
        check("R4 drive pin3", 32'(pad_drive[9 +: 3]), 32'd5);
        check("R4 bias pin3", 32'(pad_bias[6 +: 2]), 32'd2);
        check("R5 oe pin3", {31'b0, pad_oe[3]}, 32'd1);
        bus_rd(12'h030, 32'h0000_0342, "R3 ctl pin3 readback");
        bus_wr(12'h004, 32'hFFFF_FFFF);
        bus_wr(12'h010, 32'hFFFF_FFFF);
        bus_rd(12'h010, 32'h0000_03DF, "R3 ctl pin1 all ones");
        check("R3 pin0 untouched", 32'(pad_oe[0]), 32'd0);

        // R4 bias codes on pin0 and max drive on pin6
        for (int b = 0; b < 4; b++) begin
            bus_wr(12'h000, 32'(b));
            check("R4 bias code pin0", 32'(pad_bias[1:0]), 32'(b));
        end
        bus_wr(12'h060, 32'h0000_01C0);
        check("R4 drive 16mA pin6", 32'(pad_drive[18 +: 3]), 32'd7);

        // R6 output bit and read-only input bit on pin3
        bus_wr(12'h034, 32'h0000_0002);
        check("R6 pad_out pin3 high", {31'b0, pad_out[3]}, 32'd1);
        bus_rd(12'h034, 32'h0000_0002, "R6 io pin3");
        bus_wr(12'h034, 32'hFFFF_FFFD);
        check("R6 pad_out pin3 low", {31'b0, pad_out[3]}, 32'd0);
        bus_rd(12'h034, 32'h0000_0000, "R6 input bit not writable");

        // R7 synchronizer delay on pin5
        pin_in[5] = 1'b1;
        bus_rd(12'h054, 32'h0000_0000, "R7 old level on first edge");
        bus_rd(12'h054, 32'h0000_0001, "R7 new level later");

        // R8 alternate function 5 on pin2 (index 2*7+4 = 18)
        bus_wr(12'h024, 32'h0000_0000);
        alt_out[18] = 1'b1; alt_oe[18] = 1'b1;
        bus_wr(12'h020, 32'h0000_0014);
        check("R8 alt out pin2", {31'b0, pad_out[2]}, 32'd1);
        check("R8 alt oe pin2", {31'b0, pad_oe[2]}, 32'd1);
        alt_out[18] = 1'b0;
        #1;
        check("R8 alt out follows", {31'b0, pad_out[2]}, 32'd0);
        bus_wr(12'h020, 32'h0000_0000);
        check("R5 oe pin2 back to gpio", {31'b0, pad_oe[2]}, 32'd0);

        // R9 power hold
        bus_rd(12'h820, 32'h0000_0001, "R9 hold reset value");
        bus_wr(12'h820, 32'h0000_0000);
        check("R9 power_keep dropped", {31'b0, power_keep}, 32'd0);
        bus_rd(12'h820, 32'h0000_0000, "R9 hold readback");
        bus_wr(12'h820, 32'h0000_0001);
        check("R9 power_keep restored", {31'b0, power_keep}, 32'd1);

        // R10 unmapped writes and reads
        s_out = pad_out; s_oe = pad_oe; s_drv = pad_drive; s_bias = pad_bias;
        bus_wr(12'h100, 32'hFFFF_FFFF);
        bus_wr(12'h008, 32'hFFFF_FFFF);
        bus_wr(12'h7F0, 32'hFFFF_FFFF);
        bus_wr(12'h822, 32'h0000_0000);
        bus_wr(12'h031, 32'h0000_0000);
        check("R10 pad_out unchanged", 32'(pad_out), 32'(s_out));
        check("R10 pad_oe unchanged", 32'(pad_oe), 32'(s_oe));
        check("R10 pad_drive unchanged", 32'(pad_drive), 32'(s_drv));
        check("R10 pad_bias unchanged", 32'(pad_bias), 32'(s_bias));
        check("R10 power_keep unchanged", {31'b0, power_keep}, 32'd1);
        bus_rd(12'h030, 32'h0000_0342, "R10 pin3 ctl kept");
        bus_rd(12'h100, 32'h0, "R10 read beyond pins");
        bus_rd(12'h00C, 32'h0, "R10 read word 3");
        bus_rd(12'h824, 32'h0, "R10 read near hold");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R2 actual=%0d reads unanswered expected=0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule